// File: doc/BRIEF.md
# NaN-Propagating Single-Precision Minimum/Maximum Unit

This block returns the smaller or the larger of two binary32 values. It differs from the conventional floating-point min/max in one way. That operation hands back the non-NaN operand when the other is a NaN. Here, any NaN on either side forces the canonical quiet NaN onto the result. The invalid flag rises only when a signalling NaN is present.

The unit is purely combinational. It carries its own opcode decoder, which looks at the major opcode, the 3-bit function field and the 7-bit function field of an instruction. The decoder recognises the minimum and maximum encodings for half, single and double precision. It reports which format was named and whether a maximum was requested. Only the binary32 datapath is built. For any other format, or for a word that is not one of these operations, the datapath output is held at zero. The surrounding pipeline registers the outputs and routes them to the register file.

Top module: `nanprop_minmax`

## Requirements
- R1: The word is legal only when the opcode field equals 7'b1010011, the 3-bit function field is 3'b010 or 3'b011, and the 7-bit function field is one of 7'b0010100, 7'b0010101 or 7'b0010110. For any other word, `illegal_o` is 1 and `fmt_o` is 2'b11.
- R2: For a legal word, `fmt_o` is 2'b00 for function field 7'b0010100 (binary32), 2'b01 for 7'b0010101 (binary64) and 2'b10 for 7'b0010110 (binary16).
- R3: For a legal word, `sel_max_o` is 0 for function field 3'b010 (minimum) and 1 for 3'b011 (maximum). It is 0 whenever the word is illegal.
- R4: For a legal binary32 word, if either operand is a NaN of any kind (exponent all ones, mantissa nonzero), `res_o` is 32'h7FC00000.
- R5: For a legal binary32 word, `invalid_o` is 1 exactly when at least one operand is a signalling NaN, meaning a NaN whose mantissa bit 22 is 0.
- R6: For a legal binary32 word with no NaN operand, `res_o` is the ordered minimum or maximum of the two operands. The order is a sign-magnitude comparison of the bit patterns, with the infinities ordered as values. `invalid_o` is 0.
- R7: Negative zero (32'h80000000) orders below positive zero. The minimum of the pair is 32'h80000000 and the maximum is 32'h00000000, in either operand order.
- R8: When the two operands carry identical non-NaN bit patterns, `res_o` equals that pattern for both minimum and maximum.
- R9: When the word is illegal or names binary16 or binary64, `res_o` is 0 and `invalid_o` is 0, whatever the operands hold, NaNs included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_i | input | 7 | Major opcode field of the instruction |
| fn3_i | input | 3 | 3-bit function field (min/max choice) |
| fn7_i | input | 7 | 7-bit function field (format choice) |
| opa_i | input | 32 | First binary32 operand |
| opb_i | input | 32 | Second binary32 operand |
| res_o | output | 32 | Selected value, canonical NaN, or zero when inactive |
| invalid_o | output | 1 | Signalling-NaN operand seen on an active binary32 operation |
| fmt_o | output | 2 | Decoded format code: 00 single, 01 double, 10 half, 11 none |
| sel_max_o | output | 1 | 1 for maximum, 0 for minimum |
| illegal_o | output | 1 | Word is not one of the recognised min/max encodings |

## Verification
The assertions are immediate checks that are evaluated whenever the combinational logic settles. They assume the five inputs are driven to known two-state values. Operand values that appear only while the inputs are changing could otherwise be judged against a half-updated decode. The bench therefore changes all inputs together just after a falling clock edge. It reads the outputs two nanoseconds later, well away from the rising edge, so every check and assertion sees a stable, fully defined input set.

// File: rtl/nanprop_minmax_pkg.sv
package nanprop_minmax_pkg;

    localparam int unsigned EXP_W  = 8;
    localparam int unsigned MAN_W  = 23;
    localparam int unsigned WORD_W = 1 + EXP_W + MAN_W;
    localparam int unsigned MAG_W  = EXP_W + MAN_W;
    localparam int unsigned QBIT   = MAN_W - 1;

    localparam logic [6:0] OPC_FPU  = 7'b1010011;
    localparam logic [2:0] FN3_MIN  = 3'b010;
    localparam logic [2:0] FN3_MAX  = 3'b011;
    localparam logic [6:0] FN7_SGL  = 7'b0010100;
    localparam logic [6:0] FN7_DBL  = 7'b0010101;
    localparam logic [6:0] FN7_HLF  = 7'b0010110;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } sp_t;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_HALF   = 2'b10,
        FMT_NONE   = 2'b11
    } fmt_e;

    localparam sp_t CANON_NAN = '{sign: 1'b0,
                                  expo: {EXP_W{1'b1}},
                                  man:  {1'b1, {(MAN_W-1){1'b0}}}};

    // Unsigned compare of exponent and mantissa taken as one field.
    function automatic logic mag_below(sp_t x, sp_t y);
        return {x.expo, x.man} < {y.expo, y.man};
    endfunction

    function automatic logic mag_is_zero(sp_t x);
        return {x.expo, x.man} == {MAG_W{1'b0}};
    endfunction

endpackage

// File: rtl/nmm_decode.sv
module nmm_decode
    import nanprop_minmax_pkg::*;
(
    input  logic [6:0] opc_i,
    input  logic [2:0] fn3_i,
    input  logic [6:0] fn7_i,
    output fmt_e       fmt_o,
    output logic       sel_max_o,
    output logic       illegal_o
);

    logic opc_ok;
    logic fn3_ok;
    fmt_e fmt_raw;

    assign opc_ok = (opc_i == OPC_FPU);
    assign fn3_ok = (fn3_i == FN3_MIN) || (fn3_i == FN3_MAX);

    always_comb begin
        unique case (fn7_i)
            FN7_SGL: fmt_raw = FMT_SINGLE;
            FN7_DBL: fmt_raw = FMT_DOUBLE;
            FN7_HLF: fmt_raw = FMT_HALF;
            default: fmt_raw = FMT_NONE;
        endcase
    end

    assign illegal_o = !opc_ok || !fn3_ok || (fmt_raw == FMT_NONE);
    assign fmt_o     = illegal_o ? FMT_NONE : fmt_raw;
    assign sel_max_o = !illegal_o && (fn3_i == FN3_MAX);

    always_comb begin
        // R3: a maximum is only reported for an accepted encoding
        p_max_needs_legal_r3: assert (!sel_max_o || !illegal_o)
            else $error("max select raised on illegal word");
        // R1: the format code and the illegal flag agree
        p_illegal_fmt_r1: assert (illegal_o == (fmt_o == FMT_NONE))
            else $error("format code disagrees with illegal flag");
    end

endmodule

// File: rtl/nmm_classify.sv
module nmm_classify
    import nanprop_minmax_pkg::*;
(
    input  sp_t  op_i,
    output logic nan_o,
    output logic snan_o
);

    logic exp_full;
    logic man_nz;

    assign exp_full = &op_i.expo;
    assign man_nz   = |op_i.man;
    assign nan_o    = exp_full && man_nz;
    assign snan_o   = nan_o && !op_i.man[QBIT];

endmodule

// File: rtl/nmm_order.sv
module nmm_order
    import nanprop_minmax_pkg::*;
(
    input  sp_t  a_i,
    input  sp_t  b_i,
    output logic a_lt_b_o
);

    always_comb begin
        if (a_i.sign != b_i.sign) begin
            // differing signs: the negative one is lower, -0 included
            a_lt_b_o = a_i.sign;
        end else if (!a_i.sign) begin
            a_lt_b_o = mag_below(a_i, b_i);
        end else begin
            a_lt_b_o = mag_below(b_i, a_i);
        end
    end

endmodule

// File: rtl/nanprop_minmax.sv
module nanprop_minmax
    import nanprop_minmax_pkg::*;
(
    input  logic [6:0]        opc_i,
    input  logic [2:0]        fn3_i,
    input  logic [6:0]        fn7_i,
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    output logic [WORD_W-1:0] res_o,
    output logic              invalid_o,
    output logic [1:0]        fmt_o,
    output logic              sel_max_o,
    output logic              illegal_o
);

    localparam int unsigned N_OPS = 2;

    fmt_e           fmt_dec;
    sp_t            ops [N_OPS];
    logic [N_OPS-1:0] nan_v;
    logic [N_OPS-1:0] snan_v;
    logic           any_nan;
    logic           any_snan;
    logic           a_lt_b;
    logic           active;
    sp_t            pick;

    nmm_decode u_dec (
        .opc_i     (opc_i),
        .fn3_i     (fn3_i),
        .fn7_i     (fn7_i),
        .fmt_o     (fmt_dec),
        .sel_max_o (sel_max_o),
        .illegal_o (illegal_o)
    );

    assign ops[0] = sp_t'(opa_i);
    assign ops[1] = sp_t'(opb_i);

    generate
        for (genvar g = 0; g < N_OPS; g++) begin : g_cls
            nmm_classify u_cls (
                .op_i   (ops[g]),
                .nan_o  (nan_v[g]),
                .snan_o (snan_v[g])
            );
        end
    endgenerate

    nmm_order u_ord (
        .a_i      (ops[0]),
        .b_i      (ops[1]),
        .a_lt_b_o (a_lt_b)
    );

    assign any_nan  = |nan_v;
    assign any_snan = |snan_v;
    assign active   = !illegal_o && (fmt_dec == FMT_SINGLE);

    always_comb begin
        if (sel_max_o) pick = a_lt_b ? ops[1] : ops[0];
        else           pick = a_lt_b ? ops[0] : ops[1];
    end

    always_comb begin
        if (!active)      res_o = '0;
        else if (any_nan) res_o = CANON_NAN;
        else              res_o = pick;
    end

    assign invalid_o = active && any_snan;
    assign fmt_o     = fmt_dec;

    always_comb begin
        // R4: a NaN on either side yields the canonical NaN
        p_nan_canon_r4: assert (!(active && any_nan) || res_o == CANON_NAN)
            else $error("NaN operand did not give canonical NaN");
        // R6: with no NaN the result is one of the two operands
        p_pick_operand_r6: assert (!(active && !any_nan) ||
                                   res_o == opa_i || res_o == opb_i)
            else $error("result is neither operand");
        // R7: zeros of opposite sign order by sign
        p_signed_zero_r7: assert (!(active && mag_is_zero(ops[0]) &&
                                    mag_is_zero(ops[1]) &&
                                    ops[0].sign != ops[1].sign) ||
                                  res_o[WORD_W-1] == !sel_max_o)
            else $error("signed zero ordering broken");
        // R5: the invalid flag only comes with a NaN result
        p_flag_with_nan_r5: assert (!invalid_o || res_o == CANON_NAN)
            else $error("invalid flag without NaN result");
        // R9: inactive formats keep the datapath quiet
        p_inactive_quiet_r9: assert (active || (res_o == '0 && !invalid_o))
            else $error("inactive datapath drove output");
    end

endmodule

// File: tb/tb_nanprop_minmax.sv
module tb_nanprop_minmax;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  opc;
    logic [2:0]  fn3;
    logic [6:0]  fn7;
    logic [31:0] opa, opb;
    logic [31:0] res;
    logic        nv, smax, ill;
    logic [1:0]  fmt;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    nanprop_minmax dut (
        .opc_i(opc), .fn3_i(fn3), .fn7_i(fn7),
        .opa_i(opa), .opb_i(opb),
        .res_o(res), .invalid_o(nv), .fmt_o(fmt),
        .sel_max_o(smax), .illegal_o(ill)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] insn;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] res;
        logic        nv;
        logic [1:0]  fmt;
        logic        mx;
        logic        ill;
    } vec_t;

    localparam logic [31:0] MN_S = 32'h283120d3;
    localparam logic [31:0] MX_S = 32'h283130d3;
    localparam logic [31:0] MN_D = 32'h2a3120d3;
    localparam logic [31:0] MX_D = 32'h2a3130d3;
    localparam logic [31:0] MN_H = 32'h2c3120d3;
    localparam logic [31:0] QNAN = 32'h7fc00000;
    localparam int NV = 22;

    localparam vec_t VECS [NV] = '{
        '{4'd6, MN_S, 32'h3f800000, 32'h40000000, 32'h3f800000, 1'b0, 2'b00, 1'b0, 1'b0}, // R6
        '{4'd6, MX_S, 32'h3f800000, 32'h40000000, 32'h40000000, 1'b0, 2'b00, 1'b1, 1'b0}, // R6
        '{4'd6, MN_S, 32'hbf800000, 32'hc0000000, 32'hc0000000, 1'b0, 2'b00, 1'b0, 1'b0}, // R6
        '{4'd6, MX_S, 32'hbf800000, 32'hc0000000, 32'hbf800000, 1'b0, 2'b00, 1'b1, 1'b0}, // R6
        '{4'd6, MN_S, 32'h40000000, 32'hc0400000, 32'hc0400000, 1'b0, 2'b00, 1'b0, 1'b0}, // R6
        '{4'd6, MX_S, 32'hc0400000, 32'h40000000, 32'h40000000, 1'b0, 2'b00, 1'b1, 1'b0}, // R6
        '{4'd6, MN_S, 32'h7f800000, 32'h3f800000, 32'h3f800000, 1'b0, 2'b00, 1'b0, 1'b0}, // R6
        '{4'd6, MX_S, 32'h7f800000, 32'h3f800000, 32'h7f800000, 1'b0, 2'b00, 1'b1, 1'b0}, // R6
        '{4'd7, MN_S, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0, 2'b00, 1'b0, 1'b0}, // R7
        '{4'd7, MN_S, 32'h00000000, 32'h80000000, 32'h80000000, 1'b0, 2'b00, 1'b0, 1'b0}, // R7
        '{4'd7, MX_S, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0, 2'b00, 1'b1, 1'b0}, // R7
        '{4'd4, MN_S, 32'h7fc00001, 32'h3f800000, QNAN,         1'b0, 2'b00, 1'b0, 1'b0}, // R4
        '{4'd4, MX_S, 32'h3f800000, 32'hffc00000, QNAN,         1'b0, 2'b00, 1'b1, 1'b0}, // R4
        '{4'd5, MN_S, 32'h7f800001, 32'h3f800000, QNAN,         1'b1, 2'b00, 1'b0, 1'b0}, // R5
        '{4'd5, MX_S, 32'h3f800000, 32'hffa00000, QNAN,         1'b1, 2'b00, 1'b1, 1'b0}, // R5
        '{4'd8, MN_S, 32'h40400000, 32'h40400000, 32'h40400000, 1'b0, 2'b00, 1'b0, 1'b0}, // R8
        '{4'd9, MN_D, 32'h3f800000, 32'h40000000, 32'h00000000, 1'b0, 2'b01, 1'b0, 1'b0}, // R9 R2
        '{4'd9, MX_D, 32'h7f800001, 32'h40000000, 32'h00000000, 1'b0, 2'b01, 1'b1, 1'b0}, // R9 R3
        '{4'd9, MN_H, 32'h7f800001, 32'h3f800000, 32'h00000000, 1'b0, 2'b10, 1'b0, 1'b0}, // R9 R2
        '{4'd1, 32'h283100d3, 32'h7f800001, 32'h1, 32'h0, 1'b0, 2'b11, 1'b0, 1'b1},       // R1 bad fn3
        '{4'd1, 32'h283120d2, 32'h3f800000, 32'h1, 32'h0, 1'b0, 2'b11, 1'b0, 1'b1},       // R1 bad opcode
        '{4'd1, 32'h2e3130d3, 32'h3f800000, 32'h1, 32'h0, 1'b0, 2'b11, 1'b0, 1'b1}        // R1 bad fn7
    };

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] insn,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        opc = insn[6:0];
        fn3 = insn[14:12];
        fn7 = insn[31:25];
        opa = a;
        opb = b;
        #2;
    endtask

    task automatic wrap_up;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        wrap_up();
    end

    initial begin
        opc = '0; fn3 = '0; fn7 = '0; opa = '0; opb = '0;
        repeat (3) @(posedge clk);
        // idle state with all-zero word: R1 illegal, R9 quiet output
        apply(32'h0, 32'h0, 32'h0);
        chk(1, "idle illegal", {31'b0, ill}, 32'h1);
        chk(1, "idle fmt", {30'b0, fmt}, 32'h3);
        chk(9, "idle res", res, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].insn, VECS[i].a, VECS[i].b);
            chk(VECS[i].req, "res", res, VECS[i].res);
            chk(VECS[i].req, "invalid", {31'b0, nv}, {31'b0, VECS[i].nv});
            chk(VECS[i].req, "fmt (R2)", {30'b0, fmt}, {30'b0, VECS[i].fmt});
            chk(VECS[i].req, "sel_max (R3)", {31'b0, smax}, {31'b0, VECS[i].mx});
            chk(VECS[i].req, "illegal (R1)", {31'b0, ill}, {31'b0, VECS[i].ill});
        end

        // R5: both operands signalling
        apply(MN_S, 32'hff800001, 32'h7f800002);
        chk(5, "two sNaN res", res, QNAN);
        chk(5, "two sNaN flag", {31'b0, nv}, 32'h1);
        // R6: largest finite negative against smallest subnormal
        apply(MN_S, 32'h00000001, 32'hff7fffff);
        chk(6, "extreme min", res, 32'hff7fffff);
        apply(MX_S, 32'h00000001, 32'hff7fffff);
        chk(6, "extreme max", res, 32'h00000001);
        // R8: equal negative values under maximum
        apply(MX_S, 32'hc1200000, 32'hc1200000);
        chk(8, "equal max", res, 32'hc1200000);
        // R4: quiet NaN under max gives no flag
        apply(MX_S, 32'h7fffffff, 32'h7fffffff);
        chk(4, "qNaN pair res", res, QNAN);
        chk(5, "qNaN pair flag", {31'b0, nv}, 32'h0);

        wrap_up();
    end

endmodule